// File: doc/BRIEF.md
# Multichannel ADC acquisition sequencer

This block sits between a bank of interval timers and a single shared 12-bit converter fed through an analog multiplexer. Each timer raises a level flag when its channel is due for a sample. The sequencer polls those flags every cycle and services one channel at a time. For that channel it sets the multiplexer select, enables the converter, issues a one-cycle start, waits for end-of-conversion and latches the result. The result then leaves on a valid/ready port, tagged with its channel number.

Software supplies three things when it pulses `start`: the set of channels to run, a sample quota for each channel and a conversion timeout. Each channel keeps its own sample count. When a channel reaches its quota, its timer gate is dropped, so that timer stops requesting. Once every gate is low and nothing is in flight, the sequencer reports completion. A conversion that never finishes is abandoned and a sticky error bit is set.

Top module: `acq_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gate`, `flag_clr`, `conv_start`, `conv_en`, `out_valid`, `done` and `err` are all 0.
- R2: A `start` pulse loads every channel's quota from `quota[i*CNT_W +: CNT_W]` and clears its sample count. It sets `gate[i]` to `ch_enable[i]` AND (quota not zero) and clears `err`. The new `gate` value is visible in the cycle after the `start` cycle.
- R3: A flag `svc_flag[i]` is served only while `gate[i]` is 1, so flags of gated-off channels have no effect. Among the served pending flags, the lowest index wins.
- R4: The cycle after a channel is chosen, `conv_start` is 1 for exactly one cycle. In that same cycle `flag_clr` is one-hot with bit i for the chosen channel. `mux_sel` holds the channel number and `conv_en` stays 1 until the conversion ends.
- R5: `conv_eoc` is ignored in the `conv_start` cycle. The first cycle after it in which `conv_eoc` is 1 captures `conv_data`, and that captured value becomes `out_sample`.
- R6: `out_valid` rises in the cycle after capture, with `out_chan` set to the channel index in binary. `out_chan` and `out_sample` stay stable until the cycle in which `out_ready` is 1. No new channel is chosen while the word is held.
- R7: Each capture adds one to that channel's count. When the count reaches the quota, `gate[i]` falls in the cycle after the capture. A gate bit rises only through `start`.
- R8: `done` is 1 once a `start` has been seen, every gate is 0, and no conversion or output word is pending. It then stays 1 until the next `start`.
- R9: If `conv_eoc` has not been accepted and the cycle count since the `conv_start` cycle reaches `to_limit`, the conversion is dropped. Accepted means in cycles 1 to `to_limit` after the start cycle. On a drop, `err` becomes 1 and stays 1 until `start`, and no word is output. The sample is not counted.
- R10: A channel's flag is cleared only by its `flag_clr` pulse at the start of conversion. A request for that channel that arrives during its conversion is therefore served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that arms a new acquisition |
| ch_enable | input | NUM_CH | Channels selected for this acquisition |
| quota | input | NUM_CH*CNT_W | Per-channel sample quota, channel i in bits [i*CNT_W +: CNT_W] |
| to_limit | input | TO_W | Conversion timeout in cycles |
| svc_flag | input | NUM_CH | Service flags held by the timer bank |
| flag_clr | output | NUM_CH | One-cycle acknowledge of the flag being served |
| gate | output | NUM_CH | Timer gate per channel |
| mux_sel | output | CH_W | Analog multiplexer select |
| conv_en | output | 1 | Converter enable during a conversion |
| conv_start | output | 1 | One-cycle start-of-conversion |
| conv_eoc | input | 1 | Converter end-of-conversion status |
| conv_data | input | DATA_W | Converter result |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_chan | output | CH_W | Channel tag of the output word |
| out_sample | output | DATA_W | Sample of the output word |
| done | output | 1 | Acquisition complete |
| err | output | 1 | Sticky conversion-timeout error |

## Verification
The assertions assume that `start` comes only as an isolated pulse. They also assume that `svc_flag` comes from a register that drops a bit only on `flag_clr`. The bench keeps to this because its flag register is set by one-cycle request pulses and cleared only by the sequencer's acknowledge. The bench's converter drives `conv_eoc` as a short pulse some cycles after `conv_start`. Two scenarios add corner cases on top of that converter: in one, `conv_eoc` is held high through the whole conversion; in the other, `conv_eoc` is suppressed so that the timeout must fire.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,
        ST_CONV = 2'd1,
        ST_HOLD = 2'd2
    } seq_st_e;
endpackage

// File: rtl/acq_seq_pick.sv
module acq_seq_pick #(
    parameter int N    = 8,
    parameter int IW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/acq_seq_quota.sv
module acq_seq_quota #(
    parameter int N     = 8,
    parameter int CNT_W = 16,
    parameter int IW    = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N-1:0]     en_mask,
    input  logic [N*CNT_W-1:0] quota_flat,
    input  logic             hit,
    input  logic [IW-1:0]    hit_ch,
    output logic [N-1:0]     gate
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             on;
    } slot_t;

    for (genvar g = 0; g < N; g++) begin : g_slot
        slot_t slot_d, slot_q;
        logic [CNT_W-1:0] cnt_inc;

        assign cnt_inc = slot_q.cnt + 1'b1;

        always_comb begin
            slot_d = slot_q;
            if (load) begin
                slot_d.cnt = '0;
                slot_d.lim = quota_flat[g*CNT_W +: CNT_W];
                slot_d.on  = en_mask[g] && (quota_flat[g*CNT_W +: CNT_W] != '0);
            end else if (hit && (hit_ch == IW'(g))) begin
                slot_d.cnt = cnt_inc;
                if (cnt_inc == slot_q.lim) begin
                    slot_d.on = 1'b0;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign gate[g] = slot_q.on;
    end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
    import acq_seq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 12,
    parameter int CNT_W  = 16,
    parameter int TO_W   = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NUM_CH-1:0]       ch_enable,
    input  logic [NUM_CH*CNT_W-1:0] quota,
    input  logic [TO_W-1:0]         to_limit,
    input  logic [NUM_CH-1:0]       svc_flag,
    output logic [NUM_CH-1:0]       flag_clr,
    output logic [NUM_CH-1:0]       gate,
    output logic [CH_W-1:0]         mux_sel,
    output logic                    conv_en,
    output logic                    conv_start,
    input  logic                    conv_eoc,
    input  logic [DATA_W-1:0]       conv_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [CH_W-1:0]         out_chan,
    output logic [DATA_W-1:0]       out_sample,
    output logic                    done,
    output logic                    err
);
    typedef struct packed {
        seq_st_e           st;
        logic [CH_W-1:0]   ch;
        logic [TO_W-1:0]   tmr;
        logic [DATA_W-1:0] smp;
        logic              sp;
        logic [NUM_CH-1:0] clr;
        logic              armed;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NUM_CH-1:0] pending;
    logic              pick_found;
    logic [CH_W-1:0]   pick_idx;
    logic              take_hit;

    assign pending = svc_flag & gate;

    acq_seq_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
        .req   (pending),
        .found (pick_found),
        .idx   (pick_idx)
    );

    acq_seq_quota #(.N(NUM_CH), .CNT_W(CNT_W), .IW(CH_W)) u_quota (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .en_mask    (ch_enable),
        .quota_flat (quota),
        .hit        (take_hit),
        .hit_ch     (seq_q.ch),
        .gate       (gate)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.sp  = 1'b0;
        seq_d.clr = '0;
        take_hit  = 1'b0;
        if (start) begin
            seq_d.st    = ST_SCAN;
            seq_d.armed = 1'b1;
            seq_d.err   = 1'b0;
            seq_d.tmr   = '0;
        end else begin
            unique case (seq_q.st)
                ST_SCAN: begin
                    if (pick_found) begin
                        seq_d.st  = ST_CONV;
                        seq_d.ch  = pick_idx;
                        seq_d.sp  = 1'b1;
                        seq_d.clr = NUM_CH'(1) << pick_idx;
                        seq_d.tmr = '0;
                    end
                end
                ST_CONV: begin
                    if (!seq_q.sp && conv_eoc) begin
                        seq_d.smp = conv_data;
                        seq_d.st  = ST_HOLD;
                        take_hit  = 1'b1;
                    end else if (seq_q.tmr == to_limit) begin
                        seq_d.err = 1'b1;
                        seq_d.st  = ST_SCAN;
                    end else begin
                        seq_d.tmr = seq_q.tmr + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (out_ready) begin
                        seq_d.st = ST_SCAN;
                    end
                end
                default: seq_d.st = ST_SCAN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_SCAN;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign flag_clr   = seq_q.clr;
    assign mux_sel    = seq_q.ch;
    assign conv_en    = (seq_q.st == ST_CONV);
    assign conv_start = seq_q.sp;
    assign out_valid  = (seq_q.st == ST_HOLD);
    assign out_chan   = seq_q.ch;
    assign out_sample = seq_q.smp;
    assign done       = seq_q.armed && (gate == '0) && (seq_q.st == ST_SCAN);
    assign err        = seq_q.err;
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 12,
    parameter int CH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [NUM_CH-1:0] gate,
    input logic [NUM_CH-1:0] flag_clr,
    input logic              conv_start,
    input logic              conv_en,
    input logic [CH_W-1:0]   mux_sel,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CH_W-1:0]   out_chan,
    input logic [DATA_W-1:0] out_sample,
    input logic              done,
    input logic              err
);
    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_clr_with_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($countones(flag_clr) == 1));

    assert_clr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> (flag_clr == '0));

    assert_mux_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_en && !conv_start) |-> $stable(mux_sel));

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_chan) && $stable(out_sample)));

    assert_gate_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ((gate & ~$past(gate)) == '0));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    assert_err_from_conv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(conv_en));
endmodule

bind acq_seq acq_seq_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .gate       (gate),
    .flag_clr   (flag_clr),
    .conv_start (conv_start),
    .conv_en    (conv_en),
    .mux_sel    (mux_sel),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_chan   (out_chan),
    .out_sample (out_sample),
    .done       (done),
    .err        (err)
);

// File: tb/acq_seq_bench.sv
module acq_seq_bench;
    localparam int NCH = 8;
    localparam int DW  = 12;
    localparam int CW  = 16;
    localparam int TW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NCH-1:0]  ch_enable = '0;
    logic [NCH*CW-1:0] quota = '0;
    logic [TW-1:0]   to_limit = '0;
    logic [NCH-1:0]  svc_reg;
    logic [NCH-1:0]  flag_clr;
    logic [NCH-1:0]  gate;
    logic [2:0]      mux_sel;
    logic            conv_en, conv_start;
    logic            eoc_r, eoc_extra = 1'b0, eoc_kill = 1'b0;
    logic [DW-1:0]   conv_data;
    logic            out_valid, out_ready = 1'b0;
    logic [2:0]      out_chan;
    logic [DW-1:0]   out_sample;
    logic            done, err;
    logic [NCH-1:0]  req = '0;
    logic            conv_eoc;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lat = 3;
    int lat_cnt;
    int got [NCH];
    int first_chan = -1;

    assign conv_eoc = eoc_r | eoc_extra;

    always #10 clk = ~clk;

    acq_seq u_acq_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_enable(ch_enable),
        .quota(quota), .to_limit(to_limit), .svc_flag(svc_reg),
        .flag_clr(flag_clr), .gate(gate), .mux_sel(mux_sel),
        .conv_en(conv_en), .conv_start(conv_start), .conv_eoc(conv_eoc),
        .conv_data(conv_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_chan(out_chan), .out_sample(out_sample), .done(done), .err(err)
    );

    // Environment: flag register set by timer requests, converter with latency
    always @(posedge clk) begin
        if (!rst_n) begin
            svc_reg   <= '0;
            eoc_r     <= 1'b0;
            lat_cnt   <= 0;
            conv_data <= '0;
        end else begin
            svc_reg   <= (svc_reg & ~flag_clr) | req;
            conv_data <= DW'(cyc * 37 + 5);
            if (conv_start) lat_cnt <= lat;
            else if (lat_cnt > 0) lat_cnt <= lat_cnt - 1;
            eoc_r <= (lat_cnt == 1) && !conv_start && !eoc_kill;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && out_valid && out_ready) begin
            got[out_chan] <= got[out_chan] + 1;
            if (first_chan < 0) first_chan <= int'(out_chan);
        end
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Behavioural reference model
    int        m_st, m_ch, m_tmr, m_smp;
    bit        m_sp, m_armed, m_err, m_live;
    bit [NCH-1:0] m_clr, m_gate;
    int        m_cnt [NCH];
    int        m_q   [NCH];

    always @(posedge clk) begin
        int n_st;
        bit n_sp;
        bit [NCH-1:0] n_clr;
        if (!rst_n) begin
            m_st = 0; m_ch = 0; m_tmr = 0; m_smp = 0; m_sp = 0;
            m_armed = 0; m_err = 0; m_clr = '0; m_gate = '0;
            foreach (m_cnt[i]) begin m_cnt[i] = 0; m_q[i] = 0; end
            m_live = 1;
        end else if (start) begin
            m_st = 0; m_armed = 1; m_err = 0; m_tmr = 0; m_sp = 0; m_clr = '0;
            for (int i = 0; i < NCH; i++) begin
                m_cnt[i]  = 0;
                m_q[i]    = int'(quota[i*CW +: CW]);
                m_gate[i] = ch_enable[i] && (m_q[i] != 0);
            end
        end else begin
            n_st = m_st; n_sp = 0; n_clr = '0;
            if (m_st == 0) begin
                for (int i = NCH - 1; i >= 0; i--) begin
                    if (svc_reg[i] && m_gate[i]) begin
                        n_st = 1; m_ch = i; n_sp = 1; n_clr = '0; n_clr[i] = 1'b1; m_tmr = 0;
                    end
                end
            end else if (m_st == 1) begin
                if (!m_sp && conv_eoc) begin
                    m_smp = int'(conv_data);
                    n_st = 2;
                    m_cnt[m_ch]++;
                    if (m_cnt[m_ch] == m_q[m_ch]) m_gate[m_ch] = 1'b0;
                end else if (m_tmr == int'(to_limit)) begin
                    m_err = 1; n_st = 0;
                end else begin
                    m_tmr++;
                end
            end else begin
                if (out_ready) n_st = 0;
            end
            m_st = n_st; m_sp = n_sp; m_clr = n_clr;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (m_live) begin
            chk(gate == m_gate, "R2 R7 gate", gate, m_gate);
            chk(conv_start == m_sp, "R4 conv_start", conv_start, m_sp);
            chk(flag_clr == m_clr, "R4 R10 flag_clr", flag_clr, m_clr);
            chk(conv_en == (m_st == 1), "R4 R9 conv_en", conv_en, m_st == 1);
            chk(out_valid == (m_st == 2), "R6 out_valid", out_valid, m_st == 2);
            if (m_st != 0) chk(int'(mux_sel) == m_ch, "R3 mux_sel", mux_sel, m_ch);
            if (m_st == 2) begin
                chk(int'(out_chan) == m_ch, "R3 R6 out_chan", out_chan, m_ch);
                chk(int'(out_sample) == m_smp, "R5 out_sample", out_sample, m_smp);
            end
            chk(done == (m_armed && m_gate == '0 && m_st == 0), "R8 done", done,
                m_armed && m_gate == '0 && m_st == 0);
            chk(err == m_err, "R9 err", err, m_err);
        end
    end

    task automatic pulse_start(input logic [NCH-1:0] en, input logic [NCH*CW-1:0] q,
                               input int tl);
        @(negedge clk);
        ch_enable = en; quota = q; to_limit = TW'(tl);
        foreach (got[i]) got[i] = 0;
        first_chan = -1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_req(input logic [NCH-1:0] m);
        @(negedge clk); req = m;
        @(negedge clk); req = '0;
    endtask

    task automatic run_until_done(input logic [NCH-1:0] m, input int period, input int limit);
        for (int k = 0; k < limit && !done; k++) begin
            if (k % period == 0) req = m; else req = '0;
            out_ready = (k % 3) != 1;
            @(negedge clk);
        end
        req = '0; out_ready = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [NCH*CW-1:0] mkq(input int q0, q1, q2, q3, q4, q5, q6, q7);
        logic [NCH*CW-1:0] r;
        r = {CW'(q7), CW'(q6), CW'(q5), CW'(q4), CW'(q3), CW'(q2), CW'(q1), CW'(q0)};
        return r;
    endfunction

    initial begin
        foreach (got[i]) got[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(gate == '0, "R1 gate", gate, 0);
        chk(!done && !err, "R1 done/err", {done, err}, 0);
        chk(!out_valid && !conv_en && !conv_start, "R1 outputs", {out_valid, conv_en, conv_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gate == '0 && !done && flag_clr == '0, "R1 after release", gate, 0);

        // Run A: mixed quotas, one zero quota, all flags raised together
        lat = 3;
        pulse_start(8'b1010_0111, mkq(0, 2, 1, 5, 5, 3, 5, 0), 20);
        chk(gate == 8'b0010_0110, "R2 gate load", gate, 8'b0010_0110);
        chk(!done, "R8 not done while running", done, 0);
        run_until_done(8'hFF, 12, 400);
        chk(done, "R8 done after quotas", done, 1);
        chk(first_chan == 1, "R3 lowest channel first", first_chan, 1);
        chk(got[1] == 2 && got[2] == 1 && got[5] == 3, "R7 words per channel",
            got[1] * 100 + got[2] * 10 + got[5], 213);
        chk(got[0] == 0 && got[7] == 0 && got[3] == 0, "R3 gated-off channels ignored",
            got[0] + got[7] + got[3], 0);
        chk(!err, "R9 no error", err, 0);

        // Run B: request during conversion is kept
        lat = 6;
        pulse_start(8'b0000_1001, mkq(2, 0, 0, 1, 0, 0, 0, 0), 30);
        pulse_req(8'b0000_1001);
        repeat (2) @(negedge clk);
        chk(conv_en, "R10 converting", conv_en, 1);
        pulse_req(8'b0000_0001);
        out_ready = 1'b1;
        for (int k = 0; k < 80 && !done; k++) @(negedge clk);
        chk(done, "R10 second request served", done, 1);
        chk(got[0] == 2 && got[3] == 1, "R10 counts", got[0] * 10 + got[3], 21);

        // Run C: timeout
        lat = 3; eoc_kill = 1'b1;
        pulse_start(8'b0000_0001, mkq(1, 0, 0, 0, 0, 0, 0, 0), 4);
        pulse_req(8'b0000_0001);
        repeat (12) @(negedge clk);
        chk(err, "R9 timeout error", err, 1);
        chk(!done && gate == 8'h01, "R9 sample not counted", gate, 1);
        chk(got[0] == 0, "R9 no word on timeout", got[0], 0);
        eoc_kill = 1'b0;
        pulse_req(8'b0000_0001);
        for (int k = 0; k < 40 && !done; k++) @(negedge clk);
        chk(done && err, "R9 err sticky after good sample", {done, err}, 3);
        chk(got[0] == 1, "R9 retry delivered", got[0], 1);

        // Run D: end-of-conversion held high from before the start pulse
        eoc_extra = 1'b1;
        pulse_start(8'b0000_0100, mkq(0, 0, 1, 0, 0, 0, 0, 0), 10);
        chk(!err, "R2 start clears err", err, 0);
        pulse_req(8'b0000_0100);
        for (int k = 0; k < 30 && !done; k++) @(negedge clk);
        eoc_extra = 1'b0;
        chk(done && got[2] == 1, "R5 capture after start cycle", got[2], 1);

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule